// File: doc/BRIEF.md
# Shared-buffer tree sum reducer

This block collects a group of up to 2N words from an input stream into a local buffer of 2N slots. It then folds them to a single value in log2(2N) passes. In each pass, lane t adds slot t+stride into slot t, but only when t is below the current stride. The stride starts at N and halves after every pass, so the active lanes always form a contiguous run at the bottom of the buffer. The total work is 2N-1 combine steps, the same as a sequential loop over the words.

A host pulses `start` together with an operator code. It then streams words in while `in_ready` is high, and reads `result` during the single cycle in which `done` is high. The operator can be wrapping unsigned addition, unsigned maximum or unsigned minimum. A short group can be closed early with `in_last`. In that case the slots that were never written hold the operator's neutral element, so they do not change the answer.

The controller moves through four named states:
- IDLE: waits for `start`, then goes to LOAD and fills every slot with the neutral element.
- LOAD: accepts words. It goes to FOLD after the word flagged `in_last`, or after the 2N-th word.
- FOLD: runs one pass per cycle. It goes to DONE after the pass with stride 1.
- DONE: raises `done` for one cycle and always returns to IDLE.

Top module: `tree_reducer`

## Requirements
- R1: After reset, `done` and `in_ready` are 0, `result` is 0, and `in_ready` stays 0 until a start.
- R2: A `start` sampled high in IDLE makes `in_ready` 1 from the next cycle. `op_sel` is captured on that same edge: 0 selects wrapping add, 1 selects unsigned max, 2 selects unsigned min, and 3 behaves as add.
- R3: Each word accepted in LOAD (`in_valid` high while `in_ready` is high) is stored in the next slot in arrival order. After the 2N-th word, loading ends with or without `in_last`.
- R4: A word accepted with `in_last` high ends loading. Unfilled slots hold the neutral element: 0 for add and max, all ones for min. The result therefore equals the reduction of the words actually supplied.
- R5: Folding takes exactly log2(2N) cycles. `done` is high in the cycle that follows the log2(2N)-th clock edge after the edge that accepted the final word.
- R6: `done` lasts exactly one cycle. During that cycle, `result` for add is the sum of the supplied words modulo 2^DW.
- R7: During `done`, `result` is the largest supplied word in max mode and the smallest supplied word in min mode.
- R8: `start` outside IDLE, and `in_valid` outside LOAD, have no effect on the stored words or on the result.
- R9: During FOLD the stride is a single power of two that halves every cycle. Slots at index N and above are never written in FOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new group (honoured in IDLE only) |
| op_sel | input | 2 | Operator: 0 add, 1 max, 2 min, 3 add |
| in_valid | input | 1 | Input word present |
| in_data | input | DW | Input word |
| in_last | input | 1 | Current word closes the group |
| in_ready | output | 1 | High while the block accepts words |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | DW | Contents of slot 0 |

## Verification
A wrong stride schedule or a bad lane enable leaves a word counted twice or not at all. This shows up as a wrong `result` in the `done` cycle of that same group, about log2(2N) cycles after the last word. A stuck or miscounted state shifts the `done` pulse away from the predicted cycle, or makes it last two cycles, and the bench checks this on every group. Neutral padding that is not applied, or stale slots carried over from the previous group, only appear in short groups. For that reason every group length from 1 to 2N is swept under all operator codes.

// File: rtl/tree_reducer_pkg.sv
package tree_reducer_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_MAX  = 2'd1,
        OP_MIN  = 2'd2,
        OP_ADD3 = 2'd3
    } fold_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_FOLD = 2'd2,
        ST_DONE = 2'd3
    } fold_state_e;

endpackage

// File: rtl/tree_reducer_ctrl.sv
module tree_reducer_ctrl
    import tree_reducer_pkg::*;
#(
    parameter int LANES = 4,
    localparam int SLOTS = 2 * LANES,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_sel,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          clear_en,
    output logic          load_en,
    output logic [IW-1:0] load_idx,
    output logic          pass_en,
    output logic [IW-1:0] stride,
    output fold_op_e      op_q,
    output logic          in_ready,
    output logic          done
);

    fold_state_e state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] stride_q;
    logic          accept;
    logic          load_end;

    assign accept   = (state_q == ST_LOAD) && in_valid;
    assign load_end = accept && (in_last || (idx_q == IW'(SLOTS - 1)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOAD;
            ST_LOAD: if (load_end) state_d = ST_FOLD;
            ST_FOLD: if (stride_q == IW'(1)) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            stride_q <= '0;
            op_q     <= OP_ADD;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q <= '0;
                        op_q  <= fold_op_e'(op_sel);
                    end
                end
                ST_LOAD: begin
                    if (accept) idx_q <= idx_q + IW'(1);
                    if (load_end) stride_q <= IW'(LANES);
                end
                ST_FOLD: stride_q <= stride_q >> 1;
                ST_DONE: stride_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        clear_en = 1'b0;
        load_en  = 1'b0;
        pass_en  = 1'b0;
        in_ready = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: clear_en = start;
            ST_LOAD: begin
                in_ready = 1'b1;
                load_en  = in_valid;
            end
            ST_FOLD: pass_en = 1'b1;
            ST_DONE: done = 1'b1;
        endcase
    end

    assign load_idx = idx_q;
    assign stride   = stride_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_STRIDE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        pass_en |-> $countones(stride_q) == 1); // R9
    AST_STRIDE_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_en && stride_q != IW'(1)) |=> (pass_en && stride_q == ($past(stride_q) >> 1))); // R9
    AST_READY_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && load_end) |=> !in_ready); // R3

endmodule

// File: rtl/tree_reducer_lanes.sv
module tree_reducer_lanes
    import tree_reducer_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DW = 8,
    localparam int SLOTS = 2 * LANES,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_en,
    input  fold_op_e      clear_op,
    input  fold_op_e      op,
    input  logic          load_en,
    input  logic [IW-1:0] load_idx,
    input  logic [DW-1:0] load_data,
    input  logic          pass_en,
    input  logic [IW-1:0] stride,
    output logic [DW-1:0] slot0
);

    logic [DW-1:0] mem_q [SLOTS];

    function automatic logic [DW-1:0] neutral(input fold_op_e o);
        return (o == OP_MIN) ? {DW{1'b1}} : {DW{1'b0}};
    endfunction

    function automatic logic [DW-1:0] combine(input fold_op_e o,
                                              input logic [DW-1:0] a,
                                              input logic [DW-1:0] b);
        logic [DW-1:0] r;
        unique case (o)
            OP_MAX:  r = (a > b) ? a : b;
            OP_MIN:  r = (a < b) ? a : b;
            default: r = a + b;
        endcase
        return r;
    endfunction

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s < LANES) begin : g_lane
            logic [IW:0]   pidx;
            logic [DW-1:0] partner;
            logic          active;
            assign pidx    = (IW+1)'(s) + {1'b0, stride};
            assign partner = mem_q[pidx[IW-1:0]];
            assign active  = pass_en && (IW'(s) < stride);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[s] <= '0;
                end else if (clear_en) begin
                    mem_q[s] <= neutral(clear_op);
                end else if (load_en && load_idx == IW'(s)) begin
                    mem_q[s] <= load_data;
                end else if (active) begin
                    mem_q[s] <= combine(op, mem_q[s], partner);
                end
            end
        end else begin : g_upper
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[s] <= '0;
                end else if (clear_en) begin
                    mem_q[s] <= neutral(clear_op);
                end else if (load_en && load_idx == IW'(s)) begin
                    mem_q[s] <= load_data;
                end
            end
        end
    end

    assign slot0 = mem_q[0];

    AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        pass_en |=> $stable(mem_q[SLOTS-1])); // R9
    AST_TOP_LANE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_en && stride == IW'(1)) |=> $stable(mem_q[1])); // R9

endmodule

// File: rtl/tree_reducer.sv
module tree_reducer
    import tree_reducer_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DW = 8,
    localparam int SLOTS = 2 * LANES,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_sel,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          done,
    output logic [DW-1:0] result
);

    logic          clear_en;
    logic          load_en;
    logic [IW-1:0] load_idx;
    logic          pass_en;
    logic [IW-1:0] stride;
    fold_op_e      op_q;

    tree_reducer_ctrl #(.LANES(LANES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_sel   (op_sel),
        .in_valid (in_valid),
        .in_last  (in_last),
        .clear_en (clear_en),
        .load_en  (load_en),
        .load_idx (load_idx),
        .pass_en  (pass_en),
        .stride   (stride),
        .op_q     (op_q),
        .in_ready (in_ready),
        .done     (done)
    );

    tree_reducer_lanes #(.LANES(LANES), .DW(DW)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_en  (clear_en),
        .clear_op  (fold_op_e'(op_sel)),
        .op        (op_q),
        .load_en   (load_en),
        .load_idx  (load_idx),
        .load_data (in_data),
        .pass_en   (pass_en),
        .stride    (stride),
        .slot0     (result)
    );

    AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && start) |=> in_ready || $past(in_valid)); // R8
    AST_FOLD_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_en && stride == IW'(1)) |=> done); // R5

endmodule

// File: tb/tree_reducer_tb.sv
module tree_reducer_tb;

    localparam int LANES = 4;
    localparam int DW = 8;
    localparam int SLOTS = 2 * LANES;
    localparam int PASSES = $clog2(SLOTS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op_sel = 2'd0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic          in_ready;
    logic          done;
    logic [DW-1:0] result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tree_reducer #(.LANES(LANES), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .done(done), .result(result)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int word_of(input int seed, input int k);
        if (seed == 0) return 255;
        return (seed * 37 + k * 91 + 5) & 255;
    endfunction

    // one group: op, number of words, seed, flags for last usage and disturbance
    task automatic run_group(input int op, input int len, input int seed,
                             input bit use_last, input bit disturb);
        int exp;
        exp = (op == 2) ? 255 : 0;
        @(negedge clk);
        start = 1'b1;
        op_sel = 2'(op);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        op_sel = 2'(3 - op);
        chk("R2 in_ready after start", int'(in_ready), 1);
        for (int k = 0; k < len; k++) begin
            int w;
            w = word_of(seed, k);
            if (op == 1) exp = (w > exp) ? w : exp;
            else if (op == 2) exp = (w < exp) ? w : exp;
            else exp = (exp + w) & 255;
            in_valid = 1'b1;
            in_data = DW'(w);
            in_last = use_last && (k == len - 1);
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last = 1'b0;
        chk("R3 loading ended", int'(in_ready), 0);
        if (disturb) begin
            start = 1'b1;
            in_valid = 1'b1;
            in_data = '1;
        end
        for (int c = 0; c < PASSES - 1; c++) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            in_valid = 1'b0;
            chk("R5 done not early", int'(done), 0);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R5 done on time", int'(done), 1);
        if (op == 1) chk("R7 max result", int'(result), exp);
        else if (op == 2) chk("R7 min result", int'(result), exp);
        else if (len < SLOTS) chk("R4 padded add result", int'(result), exp);
        else chk("R6 add result", int'(result), exp);
        if (disturb) chk("R8 disturbed result", int'(result), exp);
        @(posedge clk);
        @(negedge clk);
        chk("R6 done single cycle", int'(done), 0);
        chk("R8 no spurious load", int'(in_ready), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 in_ready after reset", int'(in_ready), 0);
        chk("R1 result after reset", int'(result), 0);
        rst_n = 1'b1;
        // R8: words offered while idle are dropped
        @(negedge clk);
        in_valid = 1'b1;
        in_data = 8'hAA;
        in_last = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 idle ignores words", int'(in_ready), 0);
        in_valid = 1'b0;
        in_last = 1'b0;
        for (int op = 0; op < 4; op++) begin
            for (int len = 1; len <= SLOTS; len++) begin
                for (int seed = 0; seed < 3; seed++) begin
                    run_group(op, len, seed, (len < SLOTS) || (seed != 1), seed == 2);
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule